// File: doc/BRIEF.md
# Rotating-Priority One-Hot Selector

The block takes one parallel request vector per clock and marks a single set bit of it on a one-hot output. Bit positions are numbered from the left: the most significant bit is position 1 and the least significant bit is position 8. The search does not always start at position 1. It begins just after the position chosen on the last cycle that had a choice. If no set bit lies after that position, the search wraps around and takes the first set bit of the whole vector. Over a run of busy cycles this spreads the choices across all requesters instead of always favouring the leftmost one.

Inside, a mask keeps only the positions after the stored pointer. Two lowest-position encoders run side by side, one on the masked vector and one on the full vector. A source selector picks the masked result when it has a hit and the full result otherwise. The chosen index is decoded back to one-hot form and is also written into the pointer register.

The output is combinational: it follows the current input and the registered pointer. The pointer takes the new choice on the clock edge that ends the cycle. A valid flag reports whether any bit was set.

Top module: `rot_onehot_sel`

## Requirements
- R1: When the input has at least one set bit, the output has exactly one set bit.
- R2: The output bit that is set always matches a bit that is set in the current input.
- R3: Position numbering starts at the leftmost bit: vec_i[7] is position 1 and vec_i[0] is position 8. Output bit sel_o[7-k] marks position k+1.
- R4: The block first searches the positions strictly after the last chosen position, and picks the lowest-numbered set bit among them.
- R5: When no set bit lies after the last chosen position, the block picks the lowest-numbered set bit of the whole vector. This includes the case where the only set bit is at the last chosen position.
- R6: After reset, the first search starts at position 1.
- R7: An all-zero input gives an all-zero output. It does not change the stored pointer, so the next nonzero input is resolved as if the zero cycle had not happened.
- R8: The output reflects the input in the same cycle. The pointer takes the new choice at the next rising clock edge.
- R9: valid_o is high exactly when the input has at least one set bit.
- R10: Reset is synchronous and active high. Asserting it in the middle of a run sends the next search back to position 1, whatever was chosen before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vec_i | input | LANES (8) | Request vector, bit LANES-1 is position 1 |
| sel_o | output | LANES (8) | One-hot choice, zero when nothing is requested |
| valid_o | output | 1 | High when vec_i has any set bit |

## Verification
The bench places the pointer at each of the eight positions. From each one it applies all 256 input vectors and compares every cycle against an arithmetic model of the search. This covers several cases:
- An off-by-one in the mask would re-select the same position instead of moving past it.
- A missing wraparound fallback would give an empty output even though bits are set.
- A reversed bit order would choose from the wrong end of the vector.

Separate sequences check the remaining cases:
- A zero cycle in the middle of a run must leave the pointer alone; a design that cleared the pointer would restart at position 1.
- A mid-run reset must restart the search at position 1; a design that kept its state would continue after the old position.
- The worked example sequence must give the expected one-hot outputs.

// File: rtl/rps_pkg.sv
package rps_pkg;

  // Default number of request lanes.
  localparam int RPS_DEF_LANES = 8;

  // Where the current choice came from.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,  // no bit set anywhere
    SRC_AFTER = 2'd1,  // found after the stored pointer
    SRC_WRAP  = 2'd2   // wrapped around to the full vector
  } rps_src_e;

endpackage

// File: rtl/rps_after_mask.sv
module rps_after_mask #(
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [IDX_W-1:0] ptr_i,
  output logic [LANES-1:0] mask_o
);

  // Lane i is open only when it lies strictly after the pointer.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = (IDX_W'(i) > ptr_i);
  end

endmodule

// File: rtl/rps_first_set.sv
module rps_first_set #(
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest set index wins; scanning downward lets lower lanes overwrite.
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |vec_i;

endmodule

// File: rtl/rps_onehot_dec.sv
module rps_onehot_dec #(
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LANES-1:0] onehot_o
);

  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign onehot_o[i] = en_i && (idx_i == IDX_W'(i));
  end

endmodule

// File: rtl/rot_onehot_sel.sv
module rot_onehot_sel
  import rps_pkg::*;
#(
  parameter int LANES = RPS_DEF_LANES,
  parameter int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [LANES-1:0] vec_i,
  output logic [LANES-1:0] sel_o,
  output logic             valid_o
);

  // Reset value: the last lane, so the first search wraps to lane 0.
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(LANES - 1);

  // Lane index 0 is position 1, i.e. the MSB of vec_i.
  logic [LANES-1:0] vec_n;
  logic [LANES-1:0] after_mask;
  logic [LANES-1:0] vec_after;
  logic [LANES-1:0] onehot_n;
  logic             hit_after;
  logic             hit_full;
  logic [IDX_W-1:0] idx_after;
  logic [IDX_W-1:0] idx_full;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] ptr_q;
  rps_src_e         src;

  for (genvar i = 0; i < LANES; i++) begin : g_norm
    assign vec_n[i]           = vec_i[LANES-1-i];
    assign sel_o[LANES-1-i]   = onehot_n[i];
  end

  rps_after_mask #(.LANES(LANES), .IDX_W(IDX_W)) u_mask (
    .ptr_i  (ptr_q),
    .mask_o (after_mask)
  );

  assign vec_after = vec_n & after_mask;

  rps_first_set #(.LANES(LANES), .IDX_W(IDX_W)) u_enc_after (
    .vec_i (vec_after),
    .hit_o (hit_after),
    .idx_o (idx_after)
  );

  rps_first_set #(.LANES(LANES), .IDX_W(IDX_W)) u_enc_full (
    .vec_i (vec_n),
    .hit_o (hit_full),
    .idx_o (idx_full)
  );

  always_comb begin
    if (hit_after)     src = SRC_AFTER;
    else if (hit_full) src = SRC_WRAP;
    else               src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_AFTER: pick_idx = idx_after;
      SRC_WRAP:  pick_idx = idx_full;
      default:   pick_idx = ptr_q;
    endcase
  end

  assign valid_o = (src != SRC_NONE);

  rps_onehot_dec #(.LANES(LANES), .IDX_W(IDX_W)) u_dec (
    .en_i     (valid_o),
    .idx_i    (pick_idx),
    .onehot_o (onehot_n)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)        ptr_q <= PTR_RST;
    else if (valid_o) ptr_q <= pick_idx;
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (rst_i)
    (vec_i != '0) |-> ($countones(sel_o) == 1)); // R1

  AST_GRANT_IN_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_o & ~vec_i) == '0); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (vec_i == '0) |-> (sel_o == '0 && !valid_o)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |=> (ptr_q == $past(ptr_q))); // R7

  AST_WRAP_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && pick_idx <= ptr_q) |-> (vec_after == '0)); // R5

  AST_PTR_TRACK: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> (ptr_q == $past(pick_idx))); // R8

endmodule

// File: tb/rot_onehot_sel_tb_top.sv
module rot_onehot_sel_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [7:0] vec_i = 8'h00;
  logic [7:0] sel_o;
  logic       valid_o;

  int n_checks = 0;
  int n_fails  = 0;
  int mp       = 7;   // model pointer, 0-based lane (0 = position 1)
  bit done     = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rot_onehot_sel #(.LANES(8)) dut_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .vec_i   (vec_i),
    .sel_o   (sel_o),
    .valid_o (valid_o)
  );

  function automatic int ref_pick(input logic [7:0] v, input int p);
    for (int i = p + 1; i < 8; i++) if (v[7-i]) return i;
    for (int i = 0; i < 8; i++) if (v[7-i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, compare 1 ns later, then update the model.
  task automatic step(input logic [7:0] v, input string tag);
    int k;
    logic [7:0] exp_sel;
    @(negedge clk_i);
    vec_i = v;
    #1;
    k = ref_pick(v, mp);
    exp_sel = (k < 0) ? 8'h00 : (8'h80 >> k);
    check(tag, sel_o, exp_sel);
    check({tag, "/R9 valid"}, {7'd0, valid_o}, {7'd0, (v != 8'h00)});
    if (k >= 0) mp = k;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_i = 1'b1;
    vec_i = 8'h00;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_i = 1'b0;
    mp = 7;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_i = 1'b0;
    #1;
    // Reset state: zero input gives an empty output.
    check("R6 reset idle sel", sel_o, 8'h00);
    check("R6 reset idle valid", {7'd0, valid_o}, 8'h00);

    // Worked example sequence (R3, R4, R5, R6).
    step(8'b00101010, "R6");
    check("R3 example 1", sel_o, 8'b00100000);
    step(8'b01001001, "R4");
    check("R4 example 2", sel_o, 8'b00001000);
    step(8'b01010101, "R4");
    check("R4 example 3", sel_o, 8'b00000100);
    step(8'b01001000, "R5");
    check("R5 example 4", sel_o, 8'b01000000);

    // R8: output tracks a changed input within the same cycle.
    @(negedge clk_i);
    vec_i = 8'h01;
    #0.5;
    check("R8 same-cycle", sel_o, 8'h01);
    vec_i = 8'h80;
    #0.5;
    check("R8 same-cycle change", sel_o, 8'h80);
    #0.5;
    mp = 0;

    // R7: a zero cycle keeps the pointer (position 4 here).
    step(8'b00010000, "R4");
    step(8'h00, "R7");
    step(8'hFF, "R7");
    check("R7 hold after zero", sel_o, 8'b00001000);

    // R5: the only set bit is the one chosen last.
    step(8'b00001000, "R5");
    check("R5 same-bit wrap", sel_o, 8'b00001000);

    // R10: reset mid-run restarts at position 1.
    step(8'b01000000, "R4");
    do_reset();
    step(8'hFF, "R10");
    check("R10 restart", sel_o, 8'h80);

    // Exhaustive sweep: every starting pointer against every vector.
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 256; v++) begin
        string tag;
        step(8'h80 >> p, "R1");
        if (v == 0)                         tag = "R7";
        else if (ref_pick(8'(v), p) > p)    tag = "R4";
        else                                tag = "R5";
        step(8'(v), tag);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule